// File: doc/BRIEF.md
# Repeat-Aware Run-Length Scan Decompressor

This block sits between a tester's serial data pin and one scan chain. The tester delivers a compressed bitstream one bit at a time, and the block expands it into fully specified scan data, one bit per clock. Each codeword describes a run of identical bits. The run is always closed by a single bit of the opposite value.

A normal codeword has three parts. The first is a polarity bit. The second is a group prefix made of ones and ended by a zero. The third is a binary tail whose width equals the group index. Two short three-bit codewords are special: each one replays the length of the run decoded just before, with its own polarity. The length is rebuilt in a down counter that starts with a single 1 in its lowest bit. The tail is shifted in behind that 1, so the counter holds the run length plus two, and it then counts down to 2 while emitting run bits.

The tester side uses a request/valid handshake. A bit is consumed only on a clock where the block requests input and the tester marks its bit valid. The output side has a valid strobe. The block never requests input while it is emitting output. Malformed input moves the block into a sticky error state that only reset clears.

Top module: `run_repeat_decoder`

## Requirements
- R1: After reset, `inReq` is high, and `outValid` and `errFlag` are low.
- R2: The first bit of a codeword sets the run value: every run bit on `outBit` equals that bit.
- R3: For group k (1 ≤ k ≤ `KMAX`), the bits after the polarity bit are k−1 ones, then a 0, then k tail bits sent MSB first. The run length is 2^k − 2 + tail. Group 1 with tail 1 gives length 1.
- R4: After the last run bit, the next clock emits exactly one bit of the opposite value with `outValid` high. `outValid` then drops.
- R5: Codeword 0,0,0 emits a run of zeros and codeword 1,0,0 emits a run of ones. In both cases the length is the most recently stored run length, followed by the opposite bit.
- R6: A repeat codeword received before any run length has been stored raises `errFlag`. The block then stops requesting input and produces no output.
- R7: A prefix that reaches `KMAX` ones raises `errFlag`. The error state holds, with `inReq` and `outValid` low, until reset.
- R8: While `outValid` is high, `inReq` is low. A run of length L appears as L+1 consecutive valid output clocks.
- R9: A clock without `inValid` consumes nothing and changes no output. Stalls in the middle of a codeword leave the decoded result unchanged.
- R10: Every normal codeword overwrites the stored run length. Repeat codewords leave it unchanged, so repeats in a row all use the same length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Tester marks `inBit` as valid |
| inBit | input | 1 | Compressed serial data bit |
| inReq | output | 1 | Block is ready to accept a compressed bit |
| outValid | output | 1 | `outBit` carries a decoded scan bit this clock |
| outBit | output | 1 | Decoded scan data |
| errFlag | output | 1 | Sticky malformed-stream indication |

## Verification
The embedded properties assume that `inBit` has meaning only on clocks where `inValid` and `inReq` are both high. They also assume that reset is applied before the stream starts. The bench driver keeps to this: it raises `inValid` only while `inReq` is seen high, and it holds the bit for exactly one accepting clock. Prefixes at or beyond `KMAX` ones and repeat codes with no stored length are sent only in dedicated error scenarios, and each of these is followed by a fresh reset.

// File: rtl/run_repeat_pkg.sv
package run_repeat_pkg;

  typedef enum logic [2:0] {
    ST_TYPE   = 3'd0,
    ST_PREFIX = 3'd1,
    ST_TAIL   = 3'd2,
    ST_RUN    = 3'd3,
    ST_TERM   = 3'd4,
    ST_ERR    = 3'd5
  } decState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic takeType;
    logic prefInc;
    logic startTail;
    logic shiftTail;
    logic storeRun;
    logic loadSaved;
    logic decRun;
    logic termSel;
  } dpCtrl_t;

  // status from datapath to control
  typedef struct packed {
    logic grpFull;
    logic grpZero;
    logic firstGroup;
    logic savedEmpty;
    logic runLast;
  } dpStat_t;

endpackage

// File: rtl/run_repeat_datapath.sv
module run_repeat_datapath
  import run_repeat_pkg::*;
#(
  parameter int KMAX = 13
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    inBit,
  input  dpCtrl_t ctl,
  output dpStat_t stat,
  output logic    outBit
);

  localparam int CW = KMAX + 1;
  localparam int GW = (KMAX > 2) ? $clog2(KMAX) : 1;

  logic          pol;
  logic          firstGrp;
  logic [GW-1:0] grpCnt;
  logic [CW-1:0] cnt;
  logic [CW-1:0] saved;
  logic [CW-1:0] shifted;

  assign shifted = {cnt[CW-2:0], inBit};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pol      <= 1'b0;
      firstGrp <= 1'b0;
      grpCnt   <= '0;
      cnt      <= '0;
      saved    <= '0;
    end else begin
      if (ctl.takeType) begin
        pol    <= inBit;
        grpCnt <= '0;
      end
      if (ctl.prefInc)
        grpCnt <= grpCnt + GW'(1);
      if (ctl.startTail) begin
        firstGrp <= (grpCnt == '0);
        cnt      <= CW'(1);
      end
      if (ctl.shiftTail) begin
        cnt <= shifted;
        if (grpCnt != '0)
          grpCnt <= grpCnt - GW'(1);
      end
      if (ctl.storeRun)
        saved <= shifted;
      if (ctl.loadSaved)
        cnt <= saved;
      if (ctl.decRun)
        cnt <= cnt - CW'(1);
    end
  end

  always_comb begin
    stat.grpFull    = (grpCnt == GW'(KMAX - 1));
    stat.grpZero    = (grpCnt == '0);
    stat.firstGroup = firstGrp;
    stat.savedEmpty = (saved == '0);
    stat.runLast    = (cnt == CW'(3));
  end

  assign outBit = pol ^ ctl.termSel;

  // R3
  run_floor_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.decRun |-> (cnt >= CW'(3)));

  // R5
  replay_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadSaved |-> (saved >= CW'(3)));

  // R7
  group_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    grpCnt <= GW'(KMAX - 1));

endmodule

// File: rtl/run_repeat_ctrl.sv
module run_repeat_ctrl
  import run_repeat_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    inValid,
  input  logic    inBit,
  input  dpStat_t stat,
  output dpCtrl_t ctl,
  output logic    inReq,
  output logic    outValid,
  output logic    errFlag
);

  decState_e st;
  decState_e nxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) st <= ST_TYPE;
    else       st <= nxt;
  end

  always_comb begin
    ctl      = '0;
    nxt      = st;
    inReq    = 1'b0;
    outValid = 1'b0;
    errFlag  = (st == ST_ERR);
    case (st)
      ST_TYPE: begin
        inReq = 1'b1;
        if (inValid) begin
          ctl.takeType = 1'b1;
          nxt = ST_PREFIX;
        end
      end
      ST_PREFIX: begin
        inReq = 1'b1;
        if (inValid) begin
          if (inBit) begin
            if (stat.grpFull) nxt = ST_ERR;
            else              ctl.prefInc = 1'b1;
          end else begin
            ctl.startTail = 1'b1;
            nxt = ST_TAIL;
          end
        end
      end
      ST_TAIL: begin
        inReq = 1'b1;
        if (inValid) begin
          ctl.shiftTail = 1'b1;
          if (stat.grpZero) begin
            if (stat.firstGroup && !inBit) begin
              if (stat.savedEmpty) begin
                nxt = ST_ERR;
              end else begin
                ctl.loadSaved = 1'b1;
                nxt = ST_RUN;
              end
            end else begin
              ctl.storeRun = 1'b1;
              nxt = ST_RUN;
            end
          end
        end
      end
      ST_RUN: begin
        outValid   = 1'b1;
        ctl.decRun = 1'b1;
        if (stat.runLast) nxt = ST_TERM;
      end
      ST_TERM: begin
        outValid    = 1'b1;
        ctl.termSel = 1'b1;
        nxt = ST_TYPE;
      end
      ST_ERR: begin
        nxt = ST_ERR;
      end
      default: nxt = ST_ERR;
    endcase
  end

  // R8
  handshake_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(inReq && outValid));

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_ERR) |=> (st == ST_ERR));

  // R4
  term_after_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_TERM) |=> (st == ST_TYPE));

endmodule

// File: rtl/run_repeat_decoder.sv
module run_repeat_decoder
  import run_repeat_pkg::*;
#(
  parameter int KMAX = 13
) (
  input  logic clk,
  input  logic rstN,
  input  logic inValid,
  input  logic inBit,
  output logic inReq,
  output logic outValid,
  output logic outBit,
  output logic errFlag
);

  dpCtrl_t ctl;
  dpStat_t stat;

  run_repeat_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inBit    (inBit),
    .stat     (stat),
    .ctl      (ctl),
    .inReq    (inReq),
    .outValid (outValid),
    .errFlag  (errFlag)
  );

  run_repeat_datapath #(.KMAX(KMAX)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .inBit  (inBit),
    .ctl    (ctl),
    .stat   (stat),
    .outBit (outBit)
  );

  // R6
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> (!outValid && !inReq));

  // R4
  term_flip_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(outValid) && !$past(ctl.termSel) && ctl.termSel)
      |-> (outBit != $past(outBit)));

endmodule

// File: tb/run_repeat_decoder_tb.sv
module run_repeat_decoder_tb;

  localparam int KMAX = 13;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic inBit = 1'b0;
  logic inReq, outValid, outBit, errFlag;

  int compared = 0;
  int mismatched = 0;
  bit expQ[$];
  string tagQ[$];

  always #4 clk = ~clk;

  run_repeat_decoder #(.KMAX(KMAX)) u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inBit(inBit),
    .inReq(inReq), .outValid(outValid), .outBit(outBit), .errFlag(errFlag)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  // monitor: pops expected scan bits
  always @(negedge clk) begin
    if (rstN && outValid) begin
      check(!inReq, "R8 request during output", inReq, 0);
      if (expQ.size() == 0) begin
        check(1'b0, "R8 unexpected output bit", outBit, -1);
      end else begin
        bit e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(outBit == e, t, outBit, e);
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    summary();
  end

  task automatic sendBit(input bit b);
    while (!inReq) @(negedge clk);
    inValid = 1'b1;
    inBit   = b;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic expectRun(input bit p, input int len, input string tag);
    for (int i = 0; i < len; i++) begin
      expQ.push_back(p);
      tagQ.push_back(tag);
    end
    expQ.push_back(~p);
    tagQ.push_back("R4 closing bit");
  endtask

  task automatic stallCheck();
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(!outValid && inReq, "R9 stall mid-codeword", outValid, 0);
    end
  endtask

  task automatic sendRun(input bit p, input int len, input bit stall);
    int k = 1;
    int tail;
    while (len > (1 << (k + 1)) - 3) k++;
    tail = len - ((1 << k) - 2);
    expectRun(p, len, p ? "R2 R3 ones run" : "R2 R3 zeros run");
    sendBit(p);
    for (int i = 0; i < k - 1; i++) sendBit(1'b1);
    sendBit(1'b0);
    for (int i = k - 1; i >= 0; i--) begin
      if (stall && i == 0) stallCheck();
      sendBit(tail[i]);
    end
  endtask

  task automatic sendRepeat(input bit p, input int len);
    expectRun(p, len, "R5 R10 replayed run");
    sendBit(p);
    sendBit(1'b0);
    sendBit(1'b0);
  endtask

  task automatic drain();
    while (expQ.size() > 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    inValid = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(inReq == 1'b1, "R1 inReq after reset", inReq, 1);
    check(outValid == 1'b0, "R1 outValid after reset", outValid, 0);
    check(errFlag == 1'b0, "R1 errFlag after reset", errFlag, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R6 repeat with nothing stored
    sendBit(1'b1); sendBit(1'b0); sendBit(1'b0);
    check(errFlag == 1'b1, "R6 error on early repeat", errFlag, 1);
    check(inReq == 1'b0, "R6 no request in error", inReq, 0);
    repeat (5) @(negedge clk);
    check(errFlag == 1'b1 && !outValid, "R6 error holds, no output", errFlag, 1);
    doReset();

    // R2 R3 explicit runs across groups
    sendRun(1'b0, 1, 1'b0);
    sendRun(1'b1, 1, 1'b0);
    sendRun(1'b0, 2, 1'b0);
    sendRun(1'b1, 5, 1'b0);
    sendRun(1'b0, 6, 1'b0);
    sendRun(1'b1, 13, 1'b0);
    sendRun(1'b0, 14, 1'b0);
    sendRun(1'b1, 29, 1'b0);
    sendRun(1'b0, 100, 1'b0);
    sendRun(1'b1, 1000, 1'b0);
    drain();

    // R5 R10 repeats
    sendRun(1'b0, 7, 1'b0);
    sendRepeat(1'b1, 7);
    sendRepeat(1'b0, 7);
    sendRun(1'b1, 3, 1'b0);
    sendRepeat(1'b1, 3);
    sendRepeat(1'b0, 3);
    drain();

    // R9 stalls inside codewords
    sendRun(1'b1, 9, 1'b1);
    sendRun(1'b0, 1, 1'b1);
    sendRun(1'b1, 40, 1'b1);
    drain();

    // largest group, then replay of that length
    sendRun(1'b1, (1 << (KMAX + 1)) - 3, 1'b0);
    sendRepeat(1'b0, (1 << (KMAX + 1)) - 3);
    drain();
    check(expQ.size() == 0 && !errFlag, "R3 max length stream clean", expQ.size(), 0);

    // R7 prefix overrun
    doReset();
    sendBit(1'b0);
    for (int i = 0; i < KMAX - 1; i++) sendBit(1'b1);
    check(errFlag == 1'b0, "R7 longest legal prefix accepted", errFlag, 0);
    sendBit(1'b1);
    check(errFlag == 1'b1, "R7 error on prefix overrun", errFlag, 1);
    check(inReq == 1'b0, "R7 no request in error", inReq, 0);
    repeat (6) @(negedge clk);
    check(errFlag == 1'b1 && !outValid && !inReq, "R7 error sticky", errFlag, 1);
    doReset();
    check(errFlag == 1'b0 && inReq, "R1 reset clears error", errFlag, 0);

    summary();
  end

endmodule